// File: doc/BRIEF.md
# Disk DMA Mode and Status Register Interface

This block is the host-facing register front end for a floppy controller and its DMA channel. The CPU sees five host registers: a data port, a mode/status register and three address bytes. A 16-bit mode value, written through the mode/status register, decides where data-port traffic goes. The access goes either to the sector count register or to one of the four controller registers, which the block selects with two address lines. Data-port reads return the byte from the controller register that the mode value selects.

The block also keeps the DMA status, a sector count and a 24-bit DMA address made of three byte registers. A transfer engine drives a small update port. It can flag an error, and it can report a finished sector, which decrements the count and moves the address on by one sector. Flipping the direction bit of the mode value between two mode writes clears both the status and the sector count. The block does not model controller behaviour or move any memory data.

Top module: `dskdma_regif`

## Requirements
- R1: After reset, a read of the mode/status register (host select 1) returns 0xFFFF0001. The DMA address reads as zero and xfer_dir is 0.
- R2: With mode bit 4 clear, a data-port write (host select 0) raises ctl_we in the same cycle. The write carries bus_wdata[7:0] on ctl_wdata, with ctl_addr = {mode bit 2, mode bit 1}: 00 is command, 01 is track, 10 is sector and 11 is data.
- R3: With mode bit 4 set, a data-port write loads bus_wdata[7:0] into the sector count and leaves ctl_we low.
- R4: A data-port read raises ctl_re in the same cycle, presents ctl_addr from mode bits 2:1 (00 selecting status), and returns {24'h0, ctl_rdata} on bus_rdata.
- R5: A mode write whose bit 8 differs from the stored bit 8 clears the sector count and the error flag. A mode write with the same bit 8 leaves both unchanged.
- R6: Status bit 0 reads 0 once eng_err has been pulsed, and stays 0 until a bit-8 toggle clears it. It reads 1 otherwise.
- R7: Status bit 1 reads 1 while the sector count is non-zero and 0 when it is zero. Status bits 15:2 read 0 and bus_rdata[31:16] reads 0xFFFF for this register.
- R8: Each eng_sector_done pulse decrements the sector count by one. The count does not go below zero.
- R9: Each eng_sector_done pulse adds 512 to the DMA address, wrapping modulo 2^24.
- R10: Host selects 2, 3 and 4 write and read the address bits 23:16, 15:8 and 7:0 respectively, each as {24'h0, byte} on read.
- R11: The output xfer_dir equals bit 8 of the stored mode value (1 means memory to disk).
- R12: In a single cycle, a bit-8 toggle takes precedence over eng_err and over the decrement, and a host count load takes precedence over the decrement. A host address-byte write cancels that cycle's address step, while a mode write does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 3 | Host register select: 0 data port, 1 mode/status, 2/3/4 address high/middle/low |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 32 | Host read data for the selected register |
| ctl_we | output | 1 | Controller register write strobe |
| ctl_re | output | 1 | Controller register read strobe |
| ctl_addr | output | 2 | Controller register address lines |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rdata | input | 8 | Controller read data |
| eng_err | input | 1 | Engine pulse: transfer error |
| eng_sector_done | input | 1 | Engine pulse: one sector transferred |
| xfer_dir | output | 1 | Transfer direction, 1 = memory to disk |

## Verification
The inline assertions check on every cycle that a direction toggle leaves the count and error flag cleared. They also check that the error flag stays set once set, that a finished sector lowers the count by one or holds it at zero, that a finished sector moves the address by one sector, and that the direction output follows the mode write. Only the bench scenarios can show the routing of data-port traffic to the controller lines and the address line encoding. The same goes for the exact 32-bit status words, the reassembly of the address from its byte registers, wrap at the top of the address space, and how simultaneous host and engine events resolve.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;
    localparam int MODE_W = 16;
    localparam int MB_LINE_LO = 1;
    localparam int MB_LINE_HI = 2;
    localparam int MB_CNT_SEL = 4;
    localparam int MB_DIR = 8;

    localparam logic [2:0] HSEL_DATA = 3'd0;
    localparam logic [2:0] HSEL_MODE = 3'd1;
    localparam logic [2:0] HSEL_ADDR0 = 3'd2;

    localparam logic [15:0] RD_UPPER_FILL = 16'hFFFF;
endpackage

// File: rtl/dskdma_mode_reg.sv
module dskdma_mode_reg
    import dskdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic              dir_flip
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.mode = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q   = st_q.mode;
    assign dir_flip = wr_en && (wdata[MB_DIR] != st_q.mode[MB_DIR]);

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/dskdma_count_status.sv
module dskdma_count_status #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             set_err,
    output logic [CNT_W-1:0] cnt_q,
    output logic             err_q,
    output logic [15:0]      status
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             err;
    } cs_st_t;

    cs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else begin
            if (load)
                st_d.cnt = load_val;
            else if (dec && st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
            if (set_err) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q  = st_q.cnt;
    assign err_q  = st_q.err;
    assign status = {14'b0, (st_q.cnt != '0), ~st_q.err};

    assert_flip_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0) && !err_q);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr) |=> err_q);

    assert_dec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_dec_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !clr && !load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/dskdma_addr_ctr.sv
module dskdma_addr_ctr #(
    parameter int ADDR_BYTES   = 3,
    parameter int SECTOR_BYTES = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_BYTES-1:0]   byte_we,
    input  logic [7:0]              wbyte,
    input  logic                    adv,
    output logic [ADDR_BYTES*8-1:0] addr_q
);
    localparam int ADDR_W = ADDR_BYTES * 8;
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(SECTOR_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ad_st_t;

    ad_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (byte_we != '0) begin
            for (int i = 0; i < ADDR_BYTES; i++)
                if (byte_we[i]) st_d.addr[i*8 +: 8] = wbyte;
        end else if (adv) begin
            st_d.addr = st_q.addr + STEP_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.addr;

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && byte_we == '0) |=> (addr_q == $past(addr_q) + STEP_V));

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && byte_we == '0) |=> $stable(addr_q));
endmodule

// File: rtl/dskdma_regif.sv
module dskdma_regif
    import dskdma_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int ADDR_BYTES   = 3,
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_sel,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ctl_we,
    output logic        ctl_re,
    output logic [1:0]  ctl_addr,
    output logic [7:0]  ctl_wdata,
    input  logic [7:0]  ctl_rdata,
    input  logic        eng_err,
    input  logic        eng_sector_done,
    output logic        xfer_dir
);
    localparam int ADDR_W = ADDR_BYTES * 8;

    logic [MODE_W-1:0]     mode_q;
    logic                  dir_flip;
    logic                  mode_we;
    logic                  data_we;
    logic                  cnt_load;
    logic [CNT_W-1:0]      cnt_q;
    logic                  err_q;
    logic [15:0]           status;
    logic [ADDR_BYTES-1:0] addr_we;
    logic [ADDR_W-1:0]     addr_q;

    assign mode_we  = bus_we && (bus_sel == HSEL_MODE);
    assign data_we  = bus_we && (bus_sel == HSEL_DATA);
    assign cnt_load = data_we && mode_q[MB_CNT_SEL];

    assign ctl_we    = data_we && !mode_q[MB_CNT_SEL];
    assign ctl_re    = bus_re && (bus_sel == HSEL_DATA);
    assign ctl_addr  = {mode_q[MB_LINE_HI], mode_q[MB_LINE_LO]};
    assign ctl_wdata = bus_wdata[7:0];
    assign xfer_dir  = mode_q[MB_DIR];

    genvar gb;
    generate
        for (gb = 0; gb < ADDR_BYTES; gb++) begin : g_addr_we
            assign addr_we[gb] = bus_we &&
                (bus_sel == HSEL_ADDR0 + 3'(ADDR_BYTES - 1 - gb));
        end
    endgenerate

    dskdma_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_we),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .dir_flip (dir_flip)
    );

    dskdma_count_status #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (dir_flip),
        .load     (cnt_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .dec      (eng_sector_done),
        .set_err  (eng_err),
        .cnt_q    (cnt_q),
        .err_q    (err_q),
        .status   (status)
    );

    dskdma_addr_ctr #(.ADDR_BYTES(ADDR_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (addr_we),
        .wbyte   (bus_wdata[7:0]),
        .adv     (eng_sector_done),
        .addr_q  (addr_q)
    );

    always_comb begin
        bus_rdata = 32'h0;
        if (bus_sel == HSEL_DATA) begin
            bus_rdata = {24'h0, ctl_rdata};
        end else if (bus_sel == HSEL_MODE) begin
            bus_rdata = {RD_UPPER_FILL, status};
        end else begin
            for (int i = 0; i < ADDR_BYTES; i++)
                if (bus_sel == HSEL_ADDR0 + 3'(ADDR_BYTES - 1 - i))
                    bus_rdata = {24'h0, addr_q[i*8 +: 8]};
        end
    end

    assert_dir_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (xfer_dir == $past(bus_wdata[MB_DIR])));

    assert_count_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && mode_q[MB_CNT_SEL] && !dir_flip) |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_err && !dir_flip) |=> err_q);
endmodule

// File: tb/dskdma_regif_tb.sv
module dskdma_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [31:0] bus_rdata;
    logic        ctl_we, ctl_re;
    logic [1:0]  ctl_addr;
    logic [7:0]  ctl_wdata;
    logic [7:0]  ctl_rdata = 8'h00;
    logic        eng_err = 1'b0;
    logic        eng_sector_done = 1'b0;
    logic        xfer_dir;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    logic        cap_we;
    logic [1:0]  cap_addr;
    logic [7:0]  cap_wdata;
    logic        cap_re;

    always #5 clk = ~clk;

    dskdma_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_we(ctl_we), .ctl_re(ctl_re),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .eng_err(eng_err), .eng_sector_done(eng_sector_done), .xfer_dir(xfer_dir)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_we = 1'b1;
        #1;
        cap_we = ctl_we; cap_addr = ctl_addr; cap_wdata = ctl_wdata;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        bus_sel = sel; bus_re = 1'b1;
        #1;
        d = bus_rdata; cap_re = ctl_re; cap_addr = ctl_addr;
        #1;
        bus_re = 1'b0;
    endtask

    task automatic eng_pulse(input logic done, input logic err);
        @(negedge clk);
        eng_sector_done = done; eng_err = err;
        @(negedge clk);
        eng_sector_done = 1'b0; eng_err = 1'b0;
    endtask

    task automatic read_addr(output logic [31:0] a);
        logic [31:0] h, m, l;
        host_rd(3'd2, h);
        host_rd(3'd3, m);
        host_rd(3'd4, l);
        a = {8'h0, h[7:0], m[7:0], l[7:0]};
    endtask

    task automatic t_reset();
        logic [31:0] r;
        host_rd(3'd1, r);
        check("R1 status after reset", r, 32'hFFFF0001);
        read_addr(r);
        check("R1 address after reset", r, 32'h0);
        check("R1 dir after reset", {31'h0, xfer_dir}, 32'h0);
    endtask

    task automatic t_ctl_write();
        host_wr(3'd1, 16'h0004);
        host_wr(3'd0, 16'h00AB);
        check("R2 ctl_we", {31'h0, cap_we}, 32'h1);
        check("R2 ctl_addr sector", {30'h0, cap_addr}, 32'h2);
        check("R2 ctl_wdata", {24'h0, cap_wdata}, 32'hAB);
        host_wr(3'd1, 16'h0106);
        check("R11 dir set", {31'h0, xfer_dir}, 32'h1);
        host_wr(3'd0, 16'h0033);
        check("R2 ctl_addr data", {30'h0, cap_addr}, 32'h3);
        host_wr(3'd1, 16'h0100);
        host_wr(3'd0, 16'h0080);
        check("R2 ctl_addr command", {30'h0, cap_addr}, 32'h0);
    endtask

    task automatic t_ctl_read();
        logic [31:0] r;
        ctl_rdata = 8'h5A;
        host_wr(3'd1, 16'h0102);
        host_rd(3'd0, r);
        check("R4 read data", r, 32'h0000005A);
        check("R4 ctl_re", {31'h0, cap_re}, 32'h1);
        check("R4 ctl_addr track", {30'h0, cap_addr}, 32'h1);
    endtask

    task automatic t_count();
        logic [31:0] r;
        host_wr(3'd1, 16'h0110);
        host_wr(3'd0, 16'h0003);
        check("R3 no ctl_we on count load", {31'h0, cap_we}, 32'h0);
        host_rd(3'd1, r);
        check("R7 count nonzero status", r, 32'hFFFF0003);
        for (int i = 0; i < 2; i++) eng_pulse(1'b1, 1'b0);
        host_rd(3'd1, r);
        check("R8 count one left", r, 32'hFFFF0003);
        eng_pulse(1'b1, 1'b0);
        host_rd(3'd1, r);
        check("R8 count reaches zero", r, 32'hFFFF0001);
        eng_pulse(1'b1, 1'b0);
        host_rd(3'd1, r);
        check("R8 count floors at zero", r, 32'hFFFF0001);
    endtask

    task automatic t_error_toggle();
        logic [31:0] r;
        eng_pulse(1'b0, 1'b1);
        host_rd(3'd1, r);
        check("R6 error clears bit0", r, 32'hFFFF0000);
        host_wr(3'd0, 16'h0004);
        host_wr(3'd1, 16'h0110);
        host_rd(3'd1, r);
        check("R5 same dir keeps state", r, 32'hFFFF0002);
        host_wr(3'd1, 16'h0010);
        host_rd(3'd1, r);
        check("R5 toggle clears count and error", r, 32'hFFFF0001);
        check("R11 dir cleared", {31'h0, xfer_dir}, 32'h0);
    endtask

    task automatic t_address();
        logic [31:0] r;
        host_wr(3'd2, 16'h0012);
        host_wr(3'd3, 16'h0034);
        host_wr(3'd4, 16'h0056);
        read_addr(r);
        check("R10 address bytes", r, 32'h00123456);
        eng_pulse(1'b1, 1'b0);
        read_addr(r);
        check("R9 address step", r, 32'h00123656);
        host_wr(3'd2, 16'h00FF);
        host_wr(3'd3, 16'h00FE);
        host_wr(3'd4, 16'h0000);
        eng_pulse(1'b1, 1'b0);
        read_addr(r);
        check("R9 address wrap", r, 32'h00000000);
    endtask

    task automatic t_priority();
        logic [31:0] r;
        logic [31:0] a0;
        host_wr(3'd1, 16'h0110);
        host_wr(3'd0, 16'h0002);
        read_addr(a0);
        @(negedge clk);
        bus_sel = 3'd1; bus_wdata = 16'h0010; bus_we = 1'b1;
        eng_err = 1'b1; eng_sector_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; eng_err = 1'b0; eng_sector_done = 1'b0;
        host_rd(3'd1, r);
        check("R12 toggle beats error and decrement", r, 32'hFFFF0001);
        read_addr(r);
        check("R12 mode write keeps address step", r, a0 + 32'h200);
        @(negedge clk);
        bus_sel = 3'd0; bus_wdata = 16'h0001; bus_we = 1'b1; eng_sector_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; eng_sector_done = 1'b0;
        host_rd(3'd1, r);
        check("R12 load beats decrement", r, 32'hFFFF0003);
        eng_pulse(1'b1, 1'b0);
        host_rd(3'd1, r);
        check("R12 loaded value was one", r, 32'hFFFF0001);
        host_wr(3'd2, 16'h0000);
        host_wr(3'd3, 16'h0010);
        host_wr(3'd4, 16'h0000);
        @(negedge clk);
        bus_sel = 3'd4; bus_wdata = 16'h0077; bus_we = 1'b1; eng_sector_done = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; eng_sector_done = 1'b0;
        read_addr(r);
        check("R12 byte write cancels step", r, 32'h00001077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl_write();
        t_ctl_read();
        t_count();
        t_error_toggle();
        t_address();
        t_priority();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule